// File: doc/BRIEF.md
# Two-level adaptive branch direction predictor

This block guesses whether a conditional branch will be taken. It uses the outcomes of recently resolved branches rather than the branch address. A shift register holds the last `HIST_BITS` outcomes, with 1 meaning taken. Its value selects one entry in a table of `2^HIST_BITS` two-bit saturating counters. The upper half of the counter's range means "taken". Because the history selects the counter, repeating outcome patterns can be learned. A single counter per branch cannot learn them.

The fetch stage raises `pred_req`. One cycle later the block returns `pred_taken`, together with `pred_idx`, which is the history value that selected the counter. The pipeline carries `pred_idx` along with the branch. When the branch resolves, the pipeline returns it on `upd_idx` with the real outcome on `upd_taken` and `upd_vld` high. On that update the selected counter steps toward the outcome, and the outcome enters the least significant history bit. If a prediction and an update happen in the same cycle, the prediction reads the table and history as they were before that update.

Top module: `bp_two_level`

## Requirements
- R1: While reset is low `pred_vld` is 0. Reset leaves the history at all zeros and every counter at strongly not taken (code 0), so the first prediction after reset reports index 0 and not taken.
- R2: `pred_vld` is 1 in the cycle after a clock edge that sampled `pred_req` high, and 0 after an edge that sampled it low.
- R3: `pred_taken` is 1 exactly when the selected counter holds weakly taken (code 2) or strongly taken (code 3). Weakly not taken (code 1) predicts not taken.
- R4: An update with `upd_taken`=1 raises the counter at `upd_idx` by one step, and a counter at strongly taken stays there.
- R5: An update with `upd_taken`=0 lowers the counter at `upd_idx` by one step, and a counter at strongly not taken stays there.
- R6: An update changes only the counter at `upd_idx`. All other counters keep their values.
- R7: An update shifts the history left by one and puts `upd_taken` in bit 0. `pred_idx` reports the history as it was at the edge that sampled the request.
- R8: A strictly alternating outcome stream is predicted without error once 16 updates have passed since reset.
- R9: A repeating taken, taken, not-taken stream is predicted without error once 24 updates have passed since reset (default `HIST_BITS` of 4).
- R10: While `upd_vld` is 0, the history and the table do not change, whatever `upd_taken` and `upd_idx` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_req | input | 1 | Fetch requests a prediction |
| pred_vld | output | 1 | Prediction result valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | HIST_BITS | History value that selected the counter |
| upd_vld | input | 1 | A resolved branch is being reported |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_idx | input | HIST_BITS | Table index saved at prediction time |

## Verification
A prediction is due one clock after the edge that samples `pred_req`. The bench drives the request at a falling edge and reads `pred_vld`, `pred_taken` and `pred_idx` at the next falling edge. An update takes effect at the edge that samples `upd_vld`. So the earliest request that can observe it is driven at the falling edge after that edge, and its result is read one cycle later. A reference model in the bench is stepped only after each of its updates is applied. A stimulus table checks the saturation corners one step at a time. Streams check that learning settles after warm-up: alternating, period-three, random, and updates aimed at indices other than the current history.

// File: rtl/bp_pkg.sv
// Shared types for the two-level branch predictor.
// Assumes two-bit counters; the code order is significant (upper half = taken).
package bp_pkg;
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;
endpackage

// File: rtl/bp_sat_step.sv
// Next-state logic of one two-bit saturating counter.
// Assumes one step per update; holds at both ends of the range.
module bp_sat_step
    import bp_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Step toward the observed outcome, saturating at the extremes.
    always_comb begin
        nxt = cur;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_SNT;
        endcase
    end
endmodule

// File: rtl/bp_hist_reg.sv
// Global outcome history: newest outcome enters at bit 0.
// Assumes at most one resolved branch per cycle.
module bp_hist_reg #(
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HW-1:0] hist
);
    // Shift in the resolved outcome; clear to all not-taken on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[HW-2:0], bit_in};
    end
endmodule

// File: rtl/bp_pattern_table.sv
// Table of 2^IW saturating counters with one prediction read port,
// one update read port and one write port.
// Assumes reads see the value stored before this cycle's write.
module bp_pattern_table
    import bp_pkg::*;
#(
    parameter int IW = 4,
    localparam int DEPTH = 1 << IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    output ctr_t             rd_ctr,
    input  logic [IW-1:0]    up_idx,
    output ctr_t             up_ctr,
    input  logic             wr_en,
    input  ctr_t             wr_val,
    output logic [2*DEPTH-1:0] flat
);
    ctr_t ctr_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Hold one counter; load it only when the write targets this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctr_q[g] <= CTR_SNT;
            else if (wr_en && (up_idx == IW'(g)))
                ctr_q[g] <= wr_val;
        end
        assign flat[2*g +: 2] = ctr_q[g];
    end

    assign rd_ctr = ctr_q[rd_idx];
    assign up_ctr = ctr_q[up_idx];
endmodule

// File: rtl/bp_two_level.sv
// Two-level adaptive branch direction predictor (global history).
// Prediction is registered one cycle after the request; updates apply at
// the edge that samples them and are visible to later requests only.
module bp_two_level
    import bp_pkg::*;
#(
    parameter int HIST_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pred_req,
    output logic                 pred_vld,
    output logic                 pred_taken,
    output logic [HIST_BITS-1:0] pred_idx,
    input  logic                 upd_vld,
    input  logic                 upd_taken,
    input  logic [HIST_BITS-1:0] upd_idx
);
    localparam int DEPTH = 1 << HIST_BITS;

    logic [HIST_BITS-1:0] ghr_q;
    ctr_t                 rd_ctr;
    ctr_t                 up_ctr;
    ctr_t                 up_nxt;
    logic [2*DEPTH-1:0]   tbl_flat;

    bp_hist_reg #(.HW(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_vld),
        .bit_in   (upd_taken),
        .hist     (ghr_q)
    );

    bp_pattern_table #(.IW(HIST_BITS)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghr_q),
        .rd_ctr (rd_ctr),
        .up_idx (upd_idx),
        .up_ctr (up_ctr),
        .wr_en  (upd_vld),
        .wr_val (up_nxt),
        .flat   (tbl_flat)
    );

    bp_sat_step u_step (
        .cur   (up_ctr),
        .taken (upd_taken),
        .nxt   (up_nxt)
    );

    // Register the prediction and the history that selected it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_vld   <= 1'b0;
            pred_taken <= 1'b0;
            pred_idx   <= '0;
        end else begin
            pred_vld <= pred_req;
            if (pred_req) begin
                pred_taken <= (rd_ctr == CTR_WT) || (rd_ctr == CTR_ST);
                pred_idx   <= ghr_q;
            end
        end
    end
endmodule

// File: rtl/bp_two_level_chk.sv
// Property checker for bp_two_level, attached by bind below.
// Assumes the history and the flattened counter table are visible by name.
module bp_two_level_chk #(
    parameter int HW = 4,
    localparam int DEPTH = 1 << HW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pred_req,
    input logic             pred_vld,
    input logic             pred_taken,
    input logic [HW-1:0]    pred_idx,
    input logic             upd_vld,
    input logic             upd_taken,
    input logic [HW-1:0]    upd_idx,
    input logic [HW-1:0]    hist,
    input logic [2*DEPTH-1:0] tbl
);
    logic          prev_vld;
    logic          prev_taken;
    logic [HW-1:0] prev_idx;
    logic [1:0]    prev_ctr;
    logic [1:0]    cur_ctr;
    logic [1:0]    hist_ctr;

    // Remember the previous update so its effect can be checked next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vld   <= 1'b0;
            prev_taken <= 1'b0;
            prev_idx   <= '0;
            prev_ctr   <= '0;
        end else begin
            prev_vld   <= upd_vld;
            prev_taken <= upd_taken;
            prev_idx   <= upd_idx;
            prev_ctr   <= tbl[2*upd_idx +: 2];
        end
    end

    assign cur_ctr  = tbl[2*prev_idx +: 2];
    assign hist_ctr = tbl[2*hist +: 2];

    AST_VLD_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> pred_vld); // R2
    AST_VLD_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req |=> !pred_vld); // R2
    AST_PRED_FROM_CTR: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> (pred_taken == $past(hist_ctr[1]))); // R3
    AST_CTR_INC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_vld && prev_taken) |-> (cur_ctr == ((prev_ctr == 2'd3) ? 2'd3 : prev_ctr + 2'd1))); // R4
    AST_CTR_DEC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_vld && !prev_taken) |-> (cur_ctr == ((prev_ctr == 2'd0) ? 2'd0 : prev_ctr - 2'd1))); // R5
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_vld |=> (hist == {$past(hist[HW-2:0]), $past(upd_taken)})); // R7
    AST_IDX_IS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> (pred_idx == $past(hist))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_vld |=> ($stable(hist) && $stable(tbl))); // R10
endmodule

bind bp_two_level bp_two_level_chk #(.HW(HIST_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_req   (pred_req),
    .pred_vld   (pred_vld),
    .pred_taken (pred_taken),
    .pred_idx   (pred_idx),
    .upd_vld    (upd_vld),
    .upd_taken  (upd_taken),
    .upd_idx    (upd_idx),
    .hist       (ghr_q),
    .tbl        (tbl_flat)
);

// File: tb/sim_bp_two_level.sv
module sim_bp_two_level;
    localparam int HB = 4;
    localparam int NE = 1 << HB;
    // Each entry: {outcome, expected index[3:0], expected prediction}
    localparam int NV = 18;
    localparam logic [5:0] VEC [NV] = '{
        6'b1_0000_0, 6'b1_0001_0, 6'b1_0011_0, 6'b1_0111_0,
        6'b1_1111_0, 6'b1_1111_0, 6'b1_1111_1, 6'b1_1111_1,
        6'b0_1111_1, 6'b0_1110_0, 6'b0_1100_0, 6'b0_1000_0,
        6'b0_0000_0, 6'b1_0000_0, 6'b1_0001_0, 6'b1_0011_0,
        6'b1_0111_0, 6'b1_1111_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_req = 1'b0;
    logic pred_vld;
    logic pred_taken;
    logic [HB-1:0] pred_idx;
    logic upd_vld = 1'b0;
    logic upd_taken = 1'b0;
    logic [HB-1:0] upd_idx = '0;

    int n_chk = 0;
    int n_bad = 0;
    int ref_ctr [NE];
    logic [HB-1:0] ref_hist;
    bit miss;
    int misses;

    always #10 clk = ~clk;

    bp_two_level #(.HIST_BITS(HB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pred_req(pred_req), .pred_vld(pred_vld),
        .pred_taken(pred_taken), .pred_idx(pred_idx),
        .upd_vld(upd_vld), .upd_taken(upd_taken), .upd_idx(upd_idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pred_req = 1'b0;
        upd_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(pred_vld == 1'b0, "R1 pred_vld in reset", int'(pred_vld), 0);
        rst_n = 1'b1;
        ref_hist = '0;
        for (int i = 0; i < NE; i++) ref_ctr[i] = 0;
    endtask

    // One predict-then-resolve step, compared with the reference model.
    task automatic step(input bit taken, input bit other_idx, input logic [HB-1:0] alt,
                        output bit mis);
        logic [HB-1:0] ui;
        bit exp_p;
        @(negedge clk);
        pred_req = 1'b1;
        @(negedge clk);
        pred_req = 1'b0;
        exp_p = (ref_ctr[ref_hist] >= 2);
        check(pred_vld == 1'b1, "R2 pred_vld after request", int'(pred_vld), 1);
        check(pred_idx == ref_hist, "R7 pred_idx", int'(pred_idx), int'(ref_hist));
        check(pred_taken == exp_p, "R3 pred_taken vs model", int'(pred_taken), int'(exp_p));
        mis = (pred_taken != taken);
        ui = other_idx ? alt : pred_idx;
        upd_vld = 1'b1;
        upd_taken = taken;
        upd_idx = ui;
        @(negedge clk);
        upd_vld = 1'b0;
        check(pred_vld == 1'b0, "R2 pred_vld idle", int'(pred_vld), 0);
        // R4 R5 R6: only the addressed counter steps, saturating
        if (taken) begin
            if (ref_ctr[ui] < 3) ref_ctr[ui]++;
        end else begin
            if (ref_ctr[ui] > 0) ref_ctr[ui]--;
        end
        ref_hist = {ref_hist[HB-2:0], taken};
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();

        // R1: first prediction after reset
        @(negedge clk);
        pred_req = 1'b1;
        @(negedge clk);
        pred_req = 1'b0;
        check(pred_idx == '0, "R1 reset index", int'(pred_idx), 0);
        check(pred_taken == 1'b0, "R1 reset prediction", int'(pred_taken), 0);

        // Table walk: saturation at both ends, weakly states (R3 R4 R5 R7)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pred_req = 1'b1;
            @(negedge clk);
            pred_req = 1'b0;
            check(pred_idx == VEC[v][4:1], "R7 table index", int'(pred_idx), int'(VEC[v][4:1]));
            check(pred_taken == VEC[v][0], "R4 R5 table prediction", int'(pred_taken), int'(VEC[v][0]));
            upd_vld = 1'b1;
            upd_taken = VEC[v][5];
            upd_idx = pred_idx;
            @(negedge clk);
            upd_vld = 1'b0;
        end

        // R10: idle update inputs change nothing
        do_reset();
        for (int k = 0; k < 6; k++) step(k[0], 1'b0, '0, miss);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            upd_taken = ~upd_taken;
            upd_idx = HB'(k * 3);
        end
        step(1'b1, 1'b0, '0, miss);
        check(1'b1, "R10 idle inputs", 0, 0);

        // R8: alternating stream
        do_reset();
        misses = 0;
        for (int k = 0; k < 40; k++) begin
            step(k[0], 1'b0, '0, miss);
            if (k >= 16 && miss) misses++;
        end
        check(misses == 0, "R8 alternating misses", misses, 0);

        // R9: period-three stream
        do_reset();
        misses = 0;
        for (int k = 0; k < 60; k++) begin
            step((k % 3) != 2, 1'b0, '0, miss);
            if (k >= 24 && miss) misses++;
        end
        check(misses == 0, "R9 period-3 misses", misses, 0);

        // R6: random outcomes, some updates aimed at other indices
        do_reset();
        for (int k = 0; k < 300; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], (r[3:2] == 2'b00), r[11:8], miss);
        end
        check(1'b1, "R6 random stream", 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule